// File: doc/BRIEF.md
# Low-Voltage Detect State Controller

This block supervises the supply-voltage monitor of a power management controller. An analog comparator, outside the block, reports when the supply has fallen below the selected threshold. The controller synchronizes that result and runs it through a three-state machine with the states detector off, detector armed and low voltage detected. It drives a live low-voltage signal, a sticky flag that software acknowledges, a status bit that mirrors the detected state, and a reset request. It also drives an enable line that powers the analog detector down whenever monitoring is not wanted.

Monitoring is allowed only when the enable bit is set. In a stop mode it also needs a separate stop-enable bit. When monitoring is not allowed, the machine falls back to the off state and the comparator is switched off to save power. The threshold-select configuration bit is not used by the state machine. It is registered and passed on to the analog side.

Top module: `lvd_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cmp_en_o`, `lv_live_o`, `status_o`, `flag_o`, `rst_req_o` and `thr_sel_o` are all 0.
- R2: When `rst` is released with monitoring allowed, `cmp_en_o` rises on the first rising edge after the release. This re-arms the machine.
- R3: A steady high on `cmp_low_i` (1 = supply below threshold), applied while the machine is armed, changes no output over the first two rising edges. It takes effect on the third rising edge, after two synchronizer flops.
- R4: On entry to the detected state, `lv_live_o`, `status_o` and `flag_o` all become 1 on the same edge.
- R5: When `cmp_low_i` returns to 0, `lv_live_o` and `status_o` clear on the third rising edge and `cmp_en_o` stays 1. `flag_o` keeps its value.
- R6: `pmode_i` is encoded as 00 run, 01 wait, 10 light stop, 11 deep stop, and bit 1 set means a stop mode. In a stop mode with `stop_en_i` = 0, the next edge moves the machine to off. `cmp_en_o`, `lv_live_o` and `status_o` become 0 and `flag_o` is kept.
- R7: In a stop mode with `stop_en_i` = 1, the detector stays on and detection works as it does in run mode.
- R8: With `en_i` = 0, the machine enters or stays in off on the next edge in every power mode, and a high `cmp_low_i` sets nothing.
- R9: `rst_req_o` is 1 exactly while the machine is in the detected state with `rst_en_i` = 1. It rises with `lv_live_o` and stays 0 when `rst_en_i` = 0.
- R10: A 1 on `ack_i` clears `flag_o` on the next edge. If a new entry to the detected state occurs on that same edge, the flag stays 1.
- R11: The wait mode (01) behaves like the run mode (00).
- R12: `thr_sel_o` takes the value of `thr_sel_i` one rising edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| cmp_low_i | input | 1 | Raw comparator result, asynchronous, 1 = supply below threshold |
| en_i | input | 1 | Monitoring enable |
| stop_en_i | input | 1 | Keep monitoring during stop modes |
| rst_en_i | input | 1 | Detection raises a reset request |
| thr_sel_i | input | 1 | Threshold-select configuration bit |
| pmode_i | input | MODE_W | Current power mode |
| ack_i | input | 1 | Write-one acknowledge of the flag |
| cmp_en_o | output | 1 | Analog comparator power enable |
| lv_live_o | output | 1 | Live low-voltage indication |
| status_o | output | 1 | Status register bit, 1 in the detected state |
| flag_o | output | 1 | Sticky detection flag |
| rst_req_o | output | 1 | Reset request |
| thr_sel_o | output | 1 | Registered threshold select for the analog side |

## Verification
Two functions can land on the same edge: the software acknowledge that clears the flag, and a fresh entry to the detected state that sets it. The bench first leaves the flag set from an earlier detection and returns the machine to the armed state. It then raises the comparator input and holds `ack_i` high in exactly the cycle before the third edge, the one on which the entry happens. The flag is expected to read 1 after that edge. A lone acknowledge one cycle later must then clear the flag.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

  typedef enum logic [1:0] {
    LVD_OFF = 2'd0,
    LVD_ON  = 2'd1,
    LVD_DET = 2'd2
  } lvd_state_e;

  localparam int STOP_BIT = 1;

  function automatic logic mode_is_stop(input logic [1:0] mode);
    return mode[STOP_BIT];
  endfunction

endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lvd_fsm.sv
module lvd_fsm
  import lvd_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              low_s_i,
  input  logic              en_i,
  input  logic              stop_en_i,
  input  logic              rst_en_i,
  input  logic [MODE_W-1:0] pmode_i,
  output lvd_state_e        state_o,
  output logic              enter_det_o,
  output logic              rst_req_o
);

  lvd_state_e state_q, state_d;
  logic       allowed;
  logic       rst_req_q;

  always_comb begin
    allowed = en_i && (!mode_is_stop(pmode_i[1:0]) || stop_en_i);
  end

  always_comb begin
    state_d = state_q;
    if (!allowed) begin
      state_d = LVD_OFF;
    end else begin
      unique case (state_q)
        LVD_OFF: state_d = LVD_ON;
        LVD_ON:  state_d = low_s_i ? LVD_DET : LVD_ON;
        LVD_DET: state_d = low_s_i ? LVD_DET : LVD_ON;
        default: state_d = LVD_OFF;
      endcase
    end
  end

  assign enter_det_o = (state_d == LVD_DET) && (state_q != LVD_DET);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= LVD_OFF;
      rst_req_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rst_req_q <= (state_d == LVD_DET) && rst_en_i;
    end
  end

  assign state_o   = state_q;
  assign rst_req_o = rst_req_q;

  AST_DISABLED_GOES_OFF: assert property (@(posedge clk) disable iff (rst)
    !(en_i && (!pmode_i[1] || stop_en_i)) |=> state_q == LVD_OFF); // R8
  AST_OFF_REARMS: assert property (@(posedge clk) disable iff (rst)
    (state_q == LVD_OFF && en_i && !pmode_i[1]) |=> state_q == LVD_ON); // R2
  AST_RECOVERY_LEAVES_DET: assert property (@(posedge clk) disable iff (rst)
    (state_q == LVD_DET && !low_s_i) |=> state_q != LVD_DET); // R5
  AST_REQ_ONLY_IN_DET: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |-> state_q == LVD_DET); // R9

endmodule

// File: rtl/lvd_regs.sv
module lvd_regs (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic ack_i,
  input  logic thr_sel_i,
  output logic flag_o,
  output logic thr_sel_o
);

  logic flag_q;
  logic thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      thr_q  <= 1'b0;
    end else begin
      thr_q <= thr_sel_i;
      if (set_i)      flag_q <= 1'b1;
      else if (ack_i) flag_q <= 1'b0;
    end
  end

  assign flag_o    = flag_q;
  assign thr_sel_o = thr_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !set_i) |=> !flag_q); // R10
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ack_i && !set_i) |=> $stable(flag_q)); // R5

endmodule

// File: rtl/lvd_ctrl.sv
module lvd_ctrl
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_low_i,
  input  logic              en_i,
  input  logic              stop_en_i,
  input  logic              rst_en_i,
  input  logic              thr_sel_i,
  input  logic [MODE_W-1:0] pmode_i,
  input  logic              ack_i,
  output logic              cmp_en_o,
  output logic              lv_live_o,
  output logic              status_o,
  output logic              flag_o,
  output logic              rst_req_o,
  output logic              thr_sel_o
);

  logic       low_s;
  logic       enter_det;
  lvd_state_e state;

  lvd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmp_low_i),
    .q_o (low_s)
  );

  lvd_fsm #(.MODE_W(MODE_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .low_s_i     (low_s),
    .en_i        (en_i),
    .stop_en_i   (stop_en_i),
    .rst_en_i    (rst_en_i),
    .pmode_i     (pmode_i),
    .state_o     (state),
    .enter_det_o (enter_det),
    .rst_req_o   (rst_req_o)
  );

  lvd_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .set_i     (enter_det),
    .ack_i     (ack_i),
    .thr_sel_i (thr_sel_i),
    .flag_o    (flag_o),
    .thr_sel_o (thr_sel_o)
  );

  assign cmp_en_o  = (state != LVD_OFF);
  assign lv_live_o = (state == LVD_DET);
  assign status_o  = (state == LVD_DET);

  AST_LIVE_NEEDS_DETECTOR: assert property (@(posedge clk) disable iff (rst)
    lv_live_o |-> cmp_en_o); // R6
  AST_LIVE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(lv_live_o) |-> flag_o); // R4
  AST_REQ_WITH_LIVE: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> lv_live_o); // R9

endmodule

// File: tb/tb_lvd_ctrl.sv
`timescale 1ns/1ps
module tb_lvd_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_low_i = 1'b0, en_i = 1'b0, stop_en_i = 1'b0, rst_en_i = 1'b0;
  logic thr_sel_i = 1'b0, ack_i = 1'b0;
  logic [1:0] pmode_i = 2'b00;
  logic cmp_en_o, lv_live_o, status_o, flag_o, rst_req_o, thr_sel_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  lvd_ctrl dut (
    .clk(clk), .rst(rst), .cmp_low_i(cmp_low_i), .en_i(en_i),
    .stop_en_i(stop_en_i), .rst_en_i(rst_en_i), .thr_sel_i(thr_sel_i),
    .pmode_i(pmode_i), .ack_i(ack_i), .cmp_en_o(cmp_en_o),
    .lv_live_o(lv_live_o), .status_o(status_o), .flag_o(flag_o),
    .rst_req_o(rst_req_o), .thr_sel_o(thr_sel_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmp_low_i = 0; en_i = 1; stop_en_i = 0; rst_en_i = 0;
    thr_sel_i = 0; ack_i = 0; pmode_i = 2'b00;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic detect();
    cmp_low_i = 1'b1;
    step(3);
  endtask

  task automatic recover();
    cmp_low_i = 1'b0;
    step(3);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; en_i = 1'b1; thr_sel_i = 1'b1; cmp_low_i = 1'b1;
    step(2);
    chk("R1 cmp_en in reset", cmp_en_o, 1'b0);
    chk("R1 live in reset", lv_live_o, 1'b0);
    chk("R1 status in reset", status_o, 1'b0);
    chk("R1 flag in reset", flag_o, 1'b0);
    chk("R1 rst_req in reset", rst_req_o, 1'b0);
    chk("R1 thr_sel in reset", thr_sel_o, 1'b0);
    cmp_low_i = 1'b0; thr_sel_i = 1'b0;
    rst = 1'b0;
    step(1);
    chk("R2 rearm after reset", cmp_en_o, 1'b1);
  endtask

  task automatic t_detect_recover();
    do_reset();
    cmp_low_i = 1'b1;
    step(2);
    chk("R3 no effect after two edges", lv_live_o, 1'b0);
    chk("R3 flag not yet", flag_o, 1'b0);
    step(1);
    chk("R3 live on third edge", lv_live_o, 1'b1);
    chk("R4 status set", status_o, 1'b1);
    chk("R4 flag set", flag_o, 1'b1);
    chk("R9 no req without rst_en", rst_req_o, 1'b0);
    cmp_low_i = 1'b0;
    step(2);
    chk("R5 live held two edges", lv_live_o, 1'b1);
    step(1);
    chk("R5 live cleared", lv_live_o, 1'b0);
    chk("R5 status cleared", status_o, 1'b0);
    chk("R5 flag kept", flag_o, 1'b1);
    chk("R5 detector still on", cmp_en_o, 1'b1);
  endtask

  task automatic t_ack_collision();
    do_reset();
    detect();
    recover();
    chk("R10 flag set before collision", flag_o, 1'b1);
    cmp_low_i = 1'b1;
    step(2);
    ack_i = 1'b1;
    step(1);
    ack_i = 1'b0;
    chk("R10 entry edge live", lv_live_o, 1'b1);
    chk("R10 set wins over ack", flag_o, 1'b1);
    ack_i = 1'b1;
    step(1);
    ack_i = 1'b0;
    chk("R10 lone ack clears", flag_o, 1'b0);
    step(1);
    chk("R10 flag stays clear", flag_o, 1'b0);
    cmp_low_i = 1'b0;
    step(3);
  endtask

  task automatic t_stop_off();
    do_reset();
    detect();
    pmode_i = 2'b10;
    step(1);
    chk("R6 detector off in stop", cmp_en_o, 1'b0);
    chk("R6 live off in stop", lv_live_o, 1'b0);
    chk("R6 status off in stop", status_o, 1'b0);
    chk("R6 flag kept in stop", flag_o, 1'b1);
    pmode_i = 2'b11;
    step(2);
    chk("R6 deep stop keeps off", cmp_en_o, 1'b0);
    pmode_i = 2'b00;
    step(1);
    chk("R6 rearmed after stop", cmp_en_o, 1'b1);
    step(1);
    chk("R6 redetect after stop", lv_live_o, 1'b1);
    cmp_low_i = 1'b0;
    step(3);
  endtask

  task automatic t_stop_on();
    do_reset();
    stop_en_i = 1'b1;
    pmode_i = 2'b11;
    step(2);
    chk("R7 detector on in stop", cmp_en_o, 1'b1);
    detect();
    chk("R7 detection in stop", lv_live_o, 1'b1);
    chk("R7 status in stop", status_o, 1'b1);
    recover();
    chk("R7 recovery in stop", lv_live_o, 1'b0);
    pmode_i = 2'b00; stop_en_i = 1'b0;
  endtask

  task automatic t_disabled();
    do_reset();
    for (int m = 0; m < 4; m++) begin
      pmode_i = m[1:0];
      stop_en_i = 1'b1;
      en_i = 1'b0;
      cmp_low_i = 1'b1;
      step(1);
      chk("R8 off when disabled", cmp_en_o, 1'b0);
      step(4);
      chk("R8 no live when disabled", lv_live_o, 1'b0);
      chk("R8 no flag when disabled", flag_o, 1'b0);
      cmp_low_i = 1'b0;
      step(3);
    end
    pmode_i = 2'b00; stop_en_i = 1'b0; en_i = 1'b1;
    step(1);
  endtask

  task automatic t_reset_req();
    do_reset();
    rst_en_i = 1'b1;
    cmp_low_i = 1'b1;
    step(2);
    chk("R9 no req before entry", rst_req_o, 1'b0);
    step(1);
    chk("R9 req with live", rst_req_o, 1'b1);
    chk("R9 live with req", lv_live_o, 1'b1);
    recover();
    chk("R9 req clears on leave", rst_req_o, 1'b0);
    rst_en_i = 1'b0;
  endtask

  task automatic t_wait_mode();
    do_reset();
    pmode_i = 2'b01;
    step(2);
    chk("R11 detector on in wait", cmp_en_o, 1'b1);
    detect();
    chk("R11 detection in wait", lv_live_o, 1'b1);
    recover();
    pmode_i = 2'b00;
  endtask

  task automatic t_thr();
    do_reset();
    thr_sel_i = 1'b1;
    chk("R12 not before edge", thr_sel_o, 1'b0);
    step(1);
    chk("R12 follows high", thr_sel_o, 1'b1);
    thr_sel_i = 1'b0;
    step(1);
    chk("R12 follows low", thr_sel_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_detect_recover();
    t_ack_collision();
    t_stop_off();
    t_stop_on();
    t_disabled();
    t_reset_req();
    t_wait_mode();
    t_thr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule